// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Relocatable Vector Table

This block sits beside a processor core and decides which interrupt the core should service next. Sixteen event sources each feed a rising-edge detector. A per-line selector routes any source to any of twelve maskable lines, numbered 4 to 15. A non-maskable line (number 1) is latched from its own input. A reset request (number 0) is raised by the block itself after every reset. Captured requests sit in a flag register. Software can set or clear individual flags through a small register port.

Each cycle, a fixed-priority encoder picks the lowest-numbered eligible request. The block then issues a one-cycle acknowledge that carries the 4-bit line number and the entry address in a vector table. Each table entry is 32 bytes, and software can move the table. While the core reports that a branch is still in flight, nothing is taken. The acknowledge has no ready input: the core must accept it in the cycle it appears. Register accesses are single-cycle. Reads are combinational from the address.

Top module: `ipc_top`

## Requirements
- R1: After reset the global enable (address 0 bit 0), the NMI enable (address 1 bit 1), every line enable, every flag and the table base all read 0. The first acknowledge after reset carries number 0 and vector 0.
- R2: Priority is strict: number 0 first, then 1, then 4, 5 and so on up to 15, which is lowest. Only one request is acknowledged at a time.
- R3: Line n (4 to 15) is taken only if all four of these are 1: the global enable, the NMI enable, its enable bit n at address 1, and its flag bit n at address 2.
- R4: Line 1 is taken when its flag is set and the NMI enable is 1, regardless of the global enable. Taking it clears the NMI enable. While the NMI enable is 0, every maskable line is held off. Writing 1 to address 1 bit 1 sets the NMI enable; writing 0 there has no effect.
- R5: While `brch_pend_i` is high, no acknowledge is produced. Pending requests are kept and are serviced once it drops.
- R6: The vector is the base plus 32 times the number. Only bits 31:10 of the base (address 5) are stored; the other bits read 0. Number 0 always gets vector 0.
- R7: `ack_o` is high for exactly one cycle and is always followed by at least one low cycle. Taking a line clears its flag. Taking a maskable line also clears the global enable.
- R8: Writing 1s to address 3 sets the matching flags, and writing 1s to address 4 clears them. Writes to address 2 are ignored. Only flag bits 1 and 4 to 15 exist.
- R9: If a flag is set and cleared in the same cycle, by an event or a set write on one side and a clear write or an acknowledge on the other, the flag ends up set.
- R10: Each line 4 to 15 has a 5-bit selector code. Lines 4 to 9 are held at address 6 and lines 10 to 15 at address 7, line 4+k or 10+k in bits [5k+4:5k]. Codes 0 to 15 pick that event source; codes 16 to 31 connect nothing. After reset, line n holds code n.
- R11: A flag is raised by a low-to-high transition of the source that feeds it, not by a level. Source indices are: 0 host, 1 and 2 the two timers, 3 the memory refresh timer, 4 to 7 the external pins, 8 to 11 the DMA channels, 12 and 13 serial port 0 transmit and receive, 14 and 15 serial port 1 transmit and receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event sources, edge-detected |
| nmi_i | input | 1 | Non-maskable request, edge-detected |
| brch_pend_i | input | 1 | High while branch delay slots are outstanding |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_num_o | output | 4 | Number of the acknowledged line |
| vec_addr_o | output | 32 | Vector table address of the acknowledged line |

## Verification
The hardest state to reach from the ports is one where several requests of different rank are pending together. A line that is fully enabled is taken one cycle after its flag rises, so the state never lasts on its own. The stimulus holds `brch_pend_i` high or keeps the global enable low while it stacks an NMI and a maskable flag, then releases the gate. The scoreboard then expects the NMI first. It expects the maskable line to stay blocked until software sets the NMI enable again. Collisions between a source edge and a clear write are driven in the same clock edge to exercise the set-wins rule.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned RST_NUM = 0;
  localparam int unsigned NMI_NUM = 1;

  typedef enum logic [2:0] {
    A_CTL  = 3'd0,
    A_ENA  = 3'd1,
    A_FLG  = 3'd2,
    A_SET  = 3'd3,
    A_CLR  = 3'd4,
    A_BASE = 3'd5,
    A_MAP0 = 3'd6,
    A_MAP1 = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/ipc_evt_map.sv
module ipc_evt_map import ipc_pkg::*; #(
  parameter int unsigned N_SRC      = 16,
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned N_LINE     = 16,
  parameter int unsigned FIRST_MASK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic nmi_i,
  input  logic [N_LINE-FIRST_MASK-1:0][SEL_W-1:0] sel_i,
  output logic [N_LINE-1:0] line_evt_o
);
  localparam int unsigned SRC_W = $clog2(N_SRC);

  logic [N_SRC-1:0] evt_q;
  logic             nmi_q;
  logic [N_SRC-1:0] rise_w;
  logic             nmi_rise_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      evt_q <= evt_i;
      nmi_q <= nmi_i;
    end
  end

  assign rise_w     = evt_i & ~evt_q;
  assign nmi_rise_w = nmi_i & ~nmi_q;

  for (genvar l = 0; l < N_LINE; l++) begin : g_line
    if (l == NMI_NUM) begin : g_nmi
      assign line_evt_o[l] = nmi_rise_w;
    end else if (l >= FIRST_MASK) begin : g_mask
      logic hit_w;
      assign hit_w = (32'(sel_i[l-FIRST_MASK]) < N_SRC);
      assign line_evt_o[l] = hit_w & rise_w[sel_i[l-FIRST_MASK][SRC_W-1:0]];
    end else begin : g_none
      assign line_evt_o[l] = 1'b0;
    end
  end
endmodule

// File: rtl/ipc_flags.sv
module ipc_flags import ipc_pkg::*; #(
  parameter int unsigned N_LINE     = 16,
  parameter int unsigned FIRST_MASK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [N_LINE-1:0] set_i,
  input  logic [N_LINE-1:0] clr_i,
  output logic [N_LINE-1:0] flag_o
);
  function automatic logic [N_LINE-1:0] impl_bits();
    logic [N_LINE-1:0] m;
    for (int i = 0; i < N_LINE; i++) m[i] = (i == NMI_NUM) || (i >= FIRST_MASK);
    return m;
  endfunction

  localparam logic [N_LINE-1:0] IMPL = impl_bits();

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= ((flag_o & ~clr_i) | set_i) & IMPL;
  end

  for (genvar b = 0; b < N_LINE; b++) begin : g_chk
    if (IMPL[b]) begin : g_impl
      a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[b] |=> flag_o[b]);
      a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[b] && !set_i[b]) |=> !flag_o[b]);
    end
  end
endmodule

// File: rtl/ipc_prio.sv
module ipc_prio #(
  parameter int unsigned NUM_W  = 4,
  parameter int unsigned N_LINE = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [N_LINE-1:0] req_i,
  output logic any_o,
  output logic [NUM_W-1:0] num_o
);
  always_comb begin
    any_o = 1'b0;
    num_o = '0;
    for (int i = N_LINE - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        num_o = NUM_W'(i);
      end
    end
  end

  a_r2_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[num_o]);
  a_r2_no_higher_left: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((req_i & ((N_LINE'(1) << num_o) - N_LINE'(1))) == '0));
endmodule

// File: rtl/ipc_top.sv
module ipc_top import ipc_pkg::*; #(
  parameter int unsigned DW         = 32,
  parameter int unsigned AW         = 3,
  parameter int unsigned NUM_W      = 4,
  parameter int unsigned FIRST_MASK = 4,
  parameter int unsigned N_SRC      = 16,
  parameter int unsigned SEL_W      = 5,
  parameter int unsigned VEC_SHIFT  = 5,
  parameter int unsigned BASE_LSB   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             nmi_i,
  input  logic             brch_pend_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             ack_o,
  output logic [NUM_W-1:0] ack_num_o,
  output logic [DW-1:0]    vec_addr_o
);
  localparam int unsigned N_LINE = 1 << NUM_W;
  localparam int unsigned N_MASK = N_LINE - FIRST_MASK;
  localparam int unsigned HALF   = N_MASK / 2;

  logic gie_q, nmie_q, rst_pend_q, ack_q;
  logic [N_MASK-1:0] ena_q;
  logic [DW-1:BASE_LSB] base_q;
  logic [N_MASK-1:0][SEL_W-1:0] map_q;
  logic [NUM_W-1:0] num_q;
  logic [DW-1:0] vec_q;

  logic [N_LINE-1:0] flag_w, line_evt_w, set_w, clr_w, req_w;
  logic grant_any_w;
  logic [NUM_W-1:0] grant_num_w;
  logic take_w, take_mask_w, take_nmi_w, take_rst_w;
  logic wr_ctl, wr_ena, wr_set, wr_clr, wr_base, wr_map0, wr_map1;
  logic [DW-1:0] vec_w, map0_w, map1_w;

  assign wr_ctl  = reg_we_i && (reg_addr_i == A_CTL);
  assign wr_ena  = reg_we_i && (reg_addr_i == A_ENA);
  assign wr_set  = reg_we_i && (reg_addr_i == A_SET);
  assign wr_clr  = reg_we_i && (reg_addr_i == A_CLR);
  assign wr_base = reg_we_i && (reg_addr_i == A_BASE);
  assign wr_map0 = reg_we_i && (reg_addr_i == A_MAP0);
  assign wr_map1 = reg_we_i && (reg_addr_i == A_MAP1);

  ipc_evt_map #(.N_SRC(N_SRC), .SEL_W(SEL_W), .N_LINE(N_LINE), .FIRST_MASK(FIRST_MASK)) u_map (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .nmi_i(nmi_i), .sel_i(map_q), .line_evt_o(line_evt_w)
  );

  assign set_w = line_evt_w | (wr_set ? reg_wdata_i[N_LINE-1:0] : '0);
  assign clr_w = (wr_clr ? reg_wdata_i[N_LINE-1:0] : '0)
               | (take_w ? (N_LINE'(1) << grant_num_w) : '0);

  ipc_flags #(.N_LINE(N_LINE), .FIRST_MASK(FIRST_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .flag_o(flag_w)
  );

  for (genvar l = 0; l < N_LINE; l++) begin : g_req
    if (l == RST_NUM) begin : g_rst
      assign req_w[l] = rst_pend_q;
    end else if (l == NMI_NUM) begin : g_nmi
      assign req_w[l] = flag_w[l] & nmie_q;
    end else if (l >= FIRST_MASK) begin : g_mask
      assign req_w[l] = flag_w[l] & ena_q[l-FIRST_MASK] & gie_q & nmie_q;
    end else begin : g_none
      assign req_w[l] = 1'b0;
    end
  end

  ipc_prio #(.NUM_W(NUM_W), .N_LINE(N_LINE)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(req_w), .any_o(grant_any_w), .num_o(grant_num_w)
  );

  assign take_w      = grant_any_w & ~brch_pend_i & ~ack_q;
  assign take_mask_w = take_w & (32'(grant_num_w) >= FIRST_MASK);
  assign take_nmi_w  = take_w & (grant_num_w == NUM_W'(NMI_NUM));
  assign take_rst_w  = take_w & (grant_num_w == NUM_W'(RST_NUM));

  assign vec_w = take_rst_w ? '0
               : ({base_q, {BASE_LSB{1'b0}}} + (DW'(grant_num_w) << VEC_SHIFT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q      <= 1'b0;
      nmie_q     <= 1'b0;
      rst_pend_q <= 1'b1;
      ack_q      <= 1'b0;
      ena_q      <= '0;
      base_q     <= '0;
      num_q      <= '0;
      vec_q      <= '0;
    end else begin
      ack_q <= take_w;
      if (take_w) begin
        num_q <= grant_num_w;
        vec_q <= vec_w;
      end
      if (take_mask_w)  gie_q <= 1'b0;
      else if (wr_ctl)  gie_q <= reg_wdata_i[0];
      if (take_nmi_w)   nmie_q <= 1'b0;
      else if (wr_ena && reg_wdata_i[NMI_NUM]) nmie_q <= 1'b1;
      if (take_rst_w)   rst_pend_q <= 1'b0;
      if (wr_ena)       ena_q <= reg_wdata_i[N_LINE-1:FIRST_MASK];
      if (wr_base)      base_q <= reg_wdata_i[DW-1:BASE_LSB];
    end
  end

  for (genvar m = 0; m < N_MASK; m++) begin : g_sel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) map_q[m] <= SEL_W'(m + FIRST_MASK);
      else if (m < HALF && wr_map0)   map_q[m] <= reg_wdata_i[(m % HALF)*SEL_W +: SEL_W];
      else if (m >= HALF && wr_map1)  map_q[m] <= reg_wdata_i[(m % HALF)*SEL_W +: SEL_W];
    end
  end

  always_comb begin
    map0_w = '0;
    map1_w = '0;
    for (int f = 0; f < HALF; f++) begin
      map0_w[f*SEL_W +: SEL_W] = map_q[f];
      map1_w[f*SEL_W +: SEL_W] = map_q[f+HALF];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTL:  reg_rdata_o[0] = gie_q;
      A_ENA:  begin
        reg_rdata_o[N_LINE-1:FIRST_MASK] = ena_q;
        reg_rdata_o[NMI_NUM] = nmie_q;
      end
      A_FLG:  reg_rdata_o[N_LINE-1:0] = flag_w;
      A_BASE: reg_rdata_o[DW-1:BASE_LSB] = base_q;
      A_MAP0: reg_rdata_o = map0_w;
      A_MAP1: reg_rdata_o = map1_w;
      default: reg_rdata_o = '0;
    endcase
  end

  assign ack_o      = ack_q;
  assign ack_num_o  = num_q;
  assign vec_addr_o = vec_q;

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
  a_r5_branch_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    brch_pend_i |=> !ack_o);
  a_r7_gie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && (32'(ack_num_o) >= FIRST_MASK)) |-> !gie_q);
  a_r4_nmie_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && (ack_num_o == NUM_W'(NMI_NUM))) |-> !nmie_q);
  a_r3_enables_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && (32'(ack_num_o) >= FIRST_MASK)) |-> $past(gie_q && nmie_q));
  a_r6_reset_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && (ack_num_o == NUM_W'(RST_NUM))) |-> (vec_addr_o == '0));
endmodule

// File: tb/ipc_top_tb.sv
module ipc_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic nmi = 1'b0, brch = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, vec;
  logic ack;
  logic [3:0] num;

  localparam logic [2:0] CTL = 3'd0, ENA = 3'd1, FLG = 3'd2, SET = 3'd3,
                         CLR = 3'd4, BASE = 3'd5, MAP0 = 3'd6, MAP1 = 3'd7;

  always #4 clk = ~clk;

  ipc_top u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .nmi_i(nmi), .brch_pend_i(brch),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_o(ack), .ack_num_o(num), .vec_addr_o(vec)
  );

  typedef struct { logic [3:0] n; logic [31:0] v; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] base_sw = '0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_ack(int n);
    exp_t e;
    e.n = 4'(n);
    e.v = (n == 0) ? 32'h0 : base_sw + 32'(32 * n);
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && ack) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R7 unexpected ack act=%h exp=none", {28'h0, num});
      end else begin
        e = sb.pop_front();
        chk(num == e.n, "R2 ack number", {28'h0, num}, {28'h0, e.n});
        chk(vec == e.v, "R6 vector", vec, e.v);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string tag);
    @(negedge clk); addr = a; #1;
    chk(rdata == e, tag, rdata, e);
  endtask

  task automatic pulse_evt(int i);
    @(negedge clk); evt[i] = 1'b1;
    @(negedge clk); evt[i] = 1'b0;
  endtask

  task automatic drain(int n, string tag);
    for (int k = 0; k < n; k++) begin
      if (sb.size() == 0) break;
      @(negedge clk); #2;
    end
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, tag, 32'(sb.size()), 32'h0);
  endtask

  task automatic idle(int n, string tag);
    repeat (n) @(negedge clk);
    chk(sb.size() == 0, tag, 32'(sb.size()), 32'h0);
  endtask

  function automatic logic [31:0] map_word(int first, int over_f, int over_v, int over2_f, int over2_v);
    logic [31:0] w = '0;
    for (int f = 0; f < 6; f++) begin
      int c = first + f;
      if (f == over_f) c = over_v;
      if (f == over2_f) c = over2_v;
      w[f*5 +: 5] = 5'(c);
    end
    return w;
  endfunction

  initial begin
    expect_ack(0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(CTL, 32'h0, "R1 global enable");
    rd(ENA, 32'h0, "R1 enables");
    rd(FLG, 32'h0, "R1 flags");
    rd(BASE, 32'h0, "R1 base");
    rd(MAP0, map_word(4, -1, 0, -1, 0), "R10 default map low");
    rd(MAP1, map_word(10, -1, 0, -1, 0), "R10 default map high");
    drain(6, "R1 reset ack");

    // R3/R4: NMI enable off blocks a maskable line
    wr(CTL, 32'h1);
    wr(ENA, 32'h1 << 11);
    wr(SET, 32'h1 << 11);
    idle(6, "R4 blocked without NMI enable");
    rd(FLG, 32'h1 << 11, "R8 set write");
    expect_ack(11);
    wr(ENA, (32'h1 << 11) | 32'h2);
    drain(6, "R3 line 11 taken");
    rd(CTL, 32'h0, "R7 global enable cleared");
    rd(FLG, 32'h0, "R7 flag cleared");

    // R2/R6: two pending lines, relocated base
    wr(BASE, 32'h0000_8000); base_sw = 32'h0000_8000;
    wr(ENA, (32'h1 << 5) | (32'h1 << 9) | 32'h2);
    wr(SET, (32'h1 << 5) | (32'h1 << 9));
    expect_ack(5);
    wr(CTL, 32'h1);
    drain(6, "R2 line 5 before 9");
    rd(FLG, 32'h1 << 9, "R2 line 9 still pending");
    expect_ack(9);
    wr(CTL, 32'h1);
    drain(6, "R2 line 9 next");

    wr(BASE, 32'h1234_5FFF); base_sw = 32'h1234_5C00;
    rd(BASE, 32'h1234_5C00, "R6 base low bits");

    // R5/R2/R4: branch pending stacks NMI over a maskable line
    @(negedge clk); brch = 1'b1;
    wr(CTL, 32'h1);
    wr(SET, 32'h1 << 5);
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); @(negedge clk); nmi = 1'b0;
    idle(5, "R5 branch blocks service");
    rd(FLG, (32'h1 << 5) | 32'h2, "R5 requests kept");
    expect_ack(1);
    @(negedge clk); brch = 1'b0;
    drain(6, "R2 NMI first");
    rd(ENA, (32'h1 << 5) | (32'h1 << 9), "R4 NMI enable cleared");
    idle(5, "R4 maskable held off");
    rd(CTL, 32'h1, "R4 global enable untouched by NMI");
    expect_ack(5);
    wr(ENA, (32'h1 << 5) | (32'h1 << 9) | 32'h2);
    drain(6, "R4 maskable after re-enable");

    // R10/R11: source mapping
    wr(ENA, (32'h1 << 7) | (32'h1 << 12) | 32'h2);
    wr(CTL, 32'h1);
    expect_ack(7);
    pulse_evt(7);
    drain(6, "R11 default source 7 to line 7");
    wr(CTL, 32'h1);
    wr(MAP1, map_word(10, 2, 2, 5, 16));
    rd(MAP1, map_word(10, 2, 2, 5, 16), "R10 map readback");
    pulse_evt(12);
    pulse_evt(15);
    idle(4, "R10 unmapped sources quiet");
    rd(FLG, 32'h0, "R10 no flag from unmapped source");
    expect_ack(12);
    pulse_evt(2);
    drain(6, "R11 timer source remapped to line 12");

    // R9: edge and clear write in the same cycle
    @(negedge clk); evt[7] = 1'b1; we = 1'b1; addr = CLR; wdata = 32'h1 << 7;
    @(negedge clk); we = 1'b0; evt[7] = 1'b0;
    rd(FLG, 32'h1 << 7, "R9 set wins over clear");
    wr(CLR, 32'h1 << 7);
    rd(FLG, 32'h0, "R8 clear write");
    wr(SET, 32'h1 << 9);
    wr(FLG, 32'h0);
    rd(FLG, 32'h1 << 9, "R8 flag writes ignored");
    wr(CLR, 32'h1 << 9);

    // R11: held level does not re-raise
    @(negedge clk); evt[7] = 1'b1;
    repeat (2) @(negedge clk);
    rd(FLG, 32'h1 << 7, "R11 edge latched");
    wr(CLR, 32'h1 << 7);
    repeat (3) @(negedge clk);
    rd(FLG, 32'h0, "R11 level ignored");
    @(negedge clk); evt[7] = 1'b0;

    // R3: line enable off
    wr(SET, 32'h1 << 9);
    wr(CTL, 32'h1);
    idle(5, "R3 disabled line not taken");
    rd(FLG, 32'h1 << 9, "R3 disabled flag kept");
    wr(CLR, 32'h1 << 9);
    wr(CTL, 32'h0);

    drain(4, "R7 scoreboard empty");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule